// File: doc/BRIEF.md
# Pacing counter source selector

This block drives a small bank of reloadable down-counters that produce periodic scan-trigger pulses. Each counter takes its count enable from a selectable clock source and its permission to count from a selectable gate source. Both are picked by writing an 8-bit configuration byte, either on the clock-select strobe or on the gate-select strobe. The clock sources are:

- a board tick input;
- the full base rate;
- four decade rates divided down from the base;
- the pulse of the neighbouring counter, which lets two counters be cascaded for long periods;
- an external tick input.

Everything runs on the single base clock. The decade rates and every other clock source are one-cycle enables, not separate clocks. A divisor register per counter sets the reload value. A counter emits a one-cycle pulse each time it reaches its terminal count. The host feeds these pulses to the conversion logic as scan triggers.

Top module: `pacer_src_top`

## Requirements
- R1: The configuration byte selects a counter with bits 4:3 and carries a 3-bit source code in bits 2:0. A byte whose bits 7:5 are not all zero, or whose index is 3, changes no selector.
- R2: Clock codes 1 to 5 advance a counter on every base cycle, every 10th, every 100th, every 1000th and every 10000th base cycle respectively. The pulse period is therefore divisor × 10^(code−1) base cycles.
- R3: Clock code 0 advances a counter once per cycle in which brd_tick is high. Clock code 7 does the same with ext_tick.
- R4: Clock code 6 advances counter n once per pulse of counter (n+2) mod 3. For counter 0 that is counter 2, so cascading two divisors multiplies the periods.
- R5: Gate code 0 lets the counter run and gate code 1 holds it. Gate code 2 follows the ext_gate level. Gate code 3 lets it run except in cycles when counter (n+1) mod 3 pulses. Codes 4 to 7 hold it. A held counter keeps its count.
- R6: A divisor write loads both the reload value and the current count. On the base rate the first pulse appears exactly divisor cycles after the write edge. A divisor of 0 means 65536.
- R7: Each pulse is high for exactly one base cycle. On that cycle the counter reloads its divisor.
- R8: After reset every counter uses clock code 0 and gate code 0, with divisor 65536, and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (the 10 MHz pacing reference) |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_cfg_wr | input | 1 | Strobe: apply cfg_byte to a clock selector |
| gate_cfg_wr | input | 1 | Strobe: apply cfg_byte to a gate selector |
| cfg_byte | input | 8 | Configuration byte: [4:3] counter, [2:0] source code, [7:5] must be zero |
| div_wr | input | 1 | Strobe: load div_val into counter div_idx |
| div_idx | input | 2 | Counter addressed by a divisor write |
| div_val | input | 16 | Divisor; 0 stands for 65536 |
| brd_tick | input | 1 | Board tick enable (clock code 0) |
| ext_tick | input | 1 | External tick enable (clock code 7) |
| ext_gate | input | 1 | External gate level (gate code 2) |
| pulse_o | output | 3 | One-cycle terminal-count pulse per counter |

## Verification
Selector and divisor writes take effect at the rising edge that samples the strobe. The counter pulse is registered, so on the base rate it rises exactly divisor edges after a divisor write. The bench counts those edges from the write and samples at falling edges. Periods are measured between two consecutive pulses rather than from a write, because the decade chain runs freely and its phase against the write is unknown. "Held" checks skip two cycles after the gate write before watching for a quiet window, so that any pulse already in flight has cleared.

// File: rtl/pacer_pkg.sv
// Shared codes for the pacing counter source selector.
// Assumes the configuration byte layout: [4:3] counter index, [2:0] code.
package pacer_pkg;
    localparam int NUM_RATES = 5;   // base rate plus four decade rates
    localparam int IDX_W     = 2;   // counter index field width
    localparam int CODE_W    = 3;   // source code field width

    typedef enum logic [CODE_W-1:0] {
        CS_BOARD = 3'd0,
        CS_R0    = 3'd1,
        CS_R1    = 3'd2,
        CS_R2    = 3'd3,
        CS_R3    = 3'd4,
        CS_R4    = 3'd5,
        CS_PREV  = 3'd6,
        CS_EXT   = 3'd7
    } clk_src_e;

    typedef enum logic [CODE_W-1:0] {
        GS_HIGH  = 3'd0,
        GS_LOW   = 3'd1,
        GS_EXT   = 3'd2,
        GS_NPREV = 3'd3,
        GS_R4    = 3'd4,
        GS_R5    = 3'd5,
        GS_R6    = 3'd6,
        GS_R7    = 3'd7
    } gate_src_e;
endpackage

// File: rtl/decade_prescaler.sv
// Chain of divide-by-RATIO enable stages running on the base clock.
// tick_o[0] is always high; tick_o[k] is high one cycle in RATIO^k.
// Assumes the consumer treats the ticks as enables in the same clock domain.
module decade_prescaler #(
    parameter int STAGES = 4,
    parameter int RATIO  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES:0]   tick_o
);
    localparam int CW = $clog2(RATIO);
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] stage_q [STAGES];

    assign tick_o[0] = 1'b1;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        assign tick_o[k+1] = tick_o[k] && (stage_q[k] == LAST);

        // advance this stage once per tick of the stage below
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[k] <= '0;
            else if (tick_o[k])
                stage_q[k] <= (stage_q[k] == LAST) ? '0 : stage_q[k] + 1'b1;
        end

        // R2
        stage_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stage_q[k] <= LAST);
    end
endmodule

// File: rtl/src_select.sv
// Clock and gate source selectors for one counter.
// Holds the two 3-bit codes, decodes configuration bytes addressed to
// this counter and muxes the chosen tick enable and gate level.
// Assumes all tick inputs are one-cycle enables on the base clock.
module src_select
    import pacer_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_wr_i,
    input  logic                 gate_wr_i,
    input  logic [7:0]           cfg_i,
    input  logic [NUM_RATES-1:0] rate_i,
    input  logic                 brd_tick_i,
    input  logic                 ext_tick_i,
    input  logic                 ext_gate_i,
    input  logic                 nb_prev_i,   // pulse of counter (n+2) mod 3
    input  logic                 nb_prev2_i,  // pulse of counter (n+1) mod 3
    output logic                 tick_o,
    output logic                 gate_o
);
    clk_src_e  clk_sel_q;
    gate_src_e gate_sel_q;
    logic      hit;

    assign hit = (cfg_i[7:5] == 3'b000) && (cfg_i[4:3] == IDX_W'(IDX));

    // latch a clock code addressed to this counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            clk_sel_q <= CS_BOARD;
        else if (clk_wr_i && hit)
            clk_sel_q <= clk_src_e'(cfg_i[2:0]);
    end

    // latch a gate code addressed to this counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_sel_q <= GS_HIGH;
        else if (gate_wr_i && hit)
            gate_sel_q <= gate_src_e'(cfg_i[2:0]);
    end

    // pick the count enable
    always_comb begin
        unique case (clk_sel_q)
            CS_BOARD: tick_o = brd_tick_i;
            CS_R0:    tick_o = rate_i[0];
            CS_R1:    tick_o = rate_i[1];
            CS_R2:    tick_o = rate_i[2];
            CS_R3:    tick_o = rate_i[3];
            CS_R4:    tick_o = rate_i[4];
            CS_PREV:  tick_o = nb_prev_i;
            CS_EXT:   tick_o = ext_tick_i;
            default:  tick_o = 1'b0;
        endcase
    end

    // pick the gate level
    always_comb begin
        unique case (gate_sel_q)
            GS_HIGH:  gate_o = 1'b1;
            GS_EXT:   gate_o = ext_gate_i;
            GS_NPREV: gate_o = ~nb_prev2_i;
            default:  gate_o = 1'b0;
        endcase
    end

    // R1
    clk_sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_wr_i && hit) |=> $stable(clk_sel_q));

    // R1
    gate_sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_wr_i && hit) |=> $stable(gate_sel_q));
endmodule

// File: rtl/reload_counter.sv
// Reloadable down-counter with a registered terminal-count pulse.
// A count value of 0 represents 2^CNT_W ticks, so a divisor of 0 gives
// the longest period. Assumes tick_i is a one-cycle enable.
module reload_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    input  logic             gate_i,
    output logic             pulse_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;

    // hold the reload value written by the host
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (load_i)
            div_q <= load_val_i;
    end

    // count down on enabled ticks, reload and pulse at terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_o <= 1'b0;
        end else if (load_i) begin
            cnt_q   <= load_val_i;
            pulse_o <= 1'b0;
        end else if (tick_i && gate_i) begin
            if (cnt_q == ONE) begin
                cnt_q   <= div_q;
                pulse_o <= 1'b1;
            end else begin
                cnt_q   <= cnt_q - ONE;
                pulse_o <= 1'b0;
            end
        end else begin
            pulse_o <= 1'b0;
        end
    end

    // R5
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !(tick_i && gate_i)) |=> $stable(cnt_q));

    // R7
    pulse_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> (cnt_q == div_q));
endmodule

// File: rtl/pacer_src_top.sv
// Top of the pacing counter source selector: one shared decade prescaler,
// and per counter a source selector and a reload counter. Neighbour
// links use modulo-NUM_CTR indexing so counter 0 sees the last counter.
// Assumes NUM_CTR fits the 2-bit index field of the configuration byte.
module pacer_src_top
    import pacer_pkg::*;
#(
    parameter int NUM_CTR = 3,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_cfg_wr,
    input  logic               gate_cfg_wr,
    input  logic [7:0]         cfg_byte,
    input  logic               div_wr,
    input  logic [IDX_W-1:0]   div_idx,
    input  logic [CNT_W-1:0]   div_val,
    input  logic               brd_tick,
    input  logic               ext_tick,
    input  logic               ext_gate,
    output logic [NUM_CTR-1:0] pulse_o
);
    logic [NUM_RATES-1:0] rate_tick;
    logic [NUM_CTR-1:0]   ctr_tick;
    logic [NUM_CTR-1:0]   ctr_gate;

    decade_prescaler #(.STAGES(NUM_RATES - 1), .RATIO(10)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (rate_tick)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        localparam int PREV  = (i + NUM_CTR - 1) % NUM_CTR;
        localparam int PREV2 = (i + NUM_CTR - 2) % NUM_CTR;

        src_select #(.IDX(i)) u_sel (
            .clk        (clk),
            .rst_n      (rst_n),
            .clk_wr_i   (clk_cfg_wr),
            .gate_wr_i  (gate_cfg_wr),
            .cfg_i      (cfg_byte),
            .rate_i     (rate_tick),
            .brd_tick_i (brd_tick),
            .ext_tick_i (ext_tick),
            .ext_gate_i (ext_gate),
            .nb_prev_i  (pulse_o[PREV]),
            .nb_prev2_i (pulse_o[PREV2]),
            .tick_o     (ctr_tick[i]),
            .gate_o     (ctr_gate[i])
        );

        reload_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (div_wr && (div_idx == IDX_W'(i))),
            .load_val_i (div_val),
            .tick_i     (ctr_tick[i]),
            .gate_i     (ctr_gate[i]),
            .pulse_o    (pulse_o[i])
        );
    end

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (pulse_o == '0));
endmodule

// File: tb/sim_pacer_src_top.sv
module sim_pacer_src_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_cfg_wr = 1'b0;
    logic        gate_cfg_wr = 1'b0;
    logic [7:0]  cfg_byte = '0;
    logic        div_wr = 1'b0;
    logic [1:0]  div_idx = '0;
    logic [15:0] div_val = '0;
    logic        brd_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic        ext_gate = 1'b0;
    logic [2:0]  pulse_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pacer_src_top u0 (
        .clk(clk), .rst_n(rst_n), .clk_cfg_wr(clk_cfg_wr),
        .gate_cfg_wr(gate_cfg_wr), .cfg_byte(cfg_byte), .div_wr(div_wr),
        .div_idx(div_idx), .div_val(div_val), .brd_tick(brd_tick),
        .ext_tick(ext_tick), .ext_gate(ext_gate), .pulse_o(pulse_o)
    );

    // board tick every 3 cycles, external tick every 5 cycles
    initial begin
        int b = 0;
        int e = 0;
        forever begin
            @(negedge clk);
            b = (b == 2) ? 0 : b + 1;
            e = (e == 4) ? 0 : e + 1;
            brd_tick = (b == 0);
            ext_tick = (e == 0);
        end
    end

    // vectors: counter, clock code, divisor, expected period in base cycles
    localparam int VN = 8;
    localparam int V_CTR [VN] = '{0, 1, 2, 0, 1, 2, 0, 1};
    localparam int V_CODE[VN] = '{1, 1, 2, 3, 4, 5, 0, 7};
    localparam int V_DIV [VN] = '{2, 7, 3, 4, 2, 2, 4, 2};
    localparam int V_EXP [VN] = '{2, 7, 30, 400, 2000, 20000, 12, 10};
    localparam string V_REQ[VN] = '{"R2", "R2", "R2", "R2", "R2", "R2", "R3", "R3"};

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic wr_clk(input logic [7:0] b);
        @(negedge clk); cfg_byte = b; clk_cfg_wr = 1'b1;
        @(negedge clk); clk_cfg_wr = 1'b0;
    endtask

    task automatic wr_gate(input logic [7:0] b);
        @(negedge clk); cfg_byte = b; gate_cfg_wr = 1'b1;
        @(negedge clk); gate_cfg_wr = 1'b0;
    endtask

    task automatic wr_div(input int c, input int v);
        @(negedge clk); div_idx = 2'(c); div_val = 16'(v); div_wr = 1'b1;
        @(negedge clk); div_wr = 1'b0;
    endtask

    function automatic logic [7:0] cb(input int c, input int code);
        return {3'b000, 2'(c), 3'(code)};
    endfunction

    // pulse-to-pulse interval, -1 if no pulse within limit
    task automatic meas(input int c, input int limit, output int per);
        int n = 0;
        per = -1;
        while (!pulse_o[c] && n < limit) begin @(negedge clk); n++; end
        if (!pulse_o[c]) return;
        n = 0;
        do begin @(negedge clk); n++; end while (!pulse_o[c] && n < limit);
        if (pulse_o[c]) per = n;
    endtask

    // number of pulses of counter c over a window
    task automatic count_pulses(input int c, input int win, output int cnt);
        cnt = 0;
        for (int k = 0; k < win; k++) begin
            @(negedge clk);
            if (pulse_o[c]) cnt++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int p;
        int cnt;
        int n;
        // R8: outputs low during and after reset
        repeat (3) @(negedge clk);
        chk("R8", "pulses in reset", int'(pulse_o), 0);
        rst_n = 1'b1;
        count_pulses(0, 20, cnt);
        chk("R8", "pulses after reset", int'(pulse_o) + cnt, 0);
        // R8: reset source is board tick, gate open: counter 2 div 4 -> 12
        wr_div(2, 4);
        meas(2, 200, p);
        chk("R8", "reset source period", p, 12);

        // vector table: R2 decade rates, R3 board/external ticks
        for (int v = 0; v < VN; v++) begin
            wr_clk(cb(V_CTR[v], V_CODE[v]));
            wr_gate(cb(V_CTR[v], 0));
            wr_div(V_CTR[v], V_DIV[v]);
            meas(V_CTR[v], 45000, p);
            chk(V_REQ[v], "period", p, V_EXP[v]);
        end

        // R6: first pulse exactly divisor cycles after the write edge
        wr_clk(cb(0, 1));
        wr_div(0, 3);
        n = 0;
        while (!pulse_o[0] && n < 100) begin @(negedge clk); n++; end
        chk("R6", "first pulse delay div3", n, 3);
        // R7: single-cycle pulse
        @(negedge clk);
        chk("R7", "pulse width", int'(pulse_o[0]), 0);

        // R6: divisor 0 stands for 65536
        wr_clk(cb(1, 1));
        wr_div(1, 0);
        n = 0;
        while (!pulse_o[1] && n < 70000) begin @(negedge clk); n++; end
        chk("R6", "first pulse delay div0", n, 65536);

        // R1: index 3 and nonzero upper bits are ignored
        wr_div(0, 2);
        wr_clk(8'b000_11_101);
        wr_clk(8'b100_00_101);
        wr_gate(8'b010_00_001);
        meas(0, 100, p);
        chk("R1", "ignored bytes keep counter 0", p, 2);

        // R4: counter 0 cascaded from counter 2
        wr_clk(cb(2, 1));
        wr_gate(cb(2, 0));
        wr_div(2, 10);
        wr_clk(cb(0, 6));
        wr_div(0, 3);
        meas(0, 200, p);
        chk("R4", "cascade period", p, 30);

        // R5: gate code 1 holds counter 1
        wr_clk(cb(1, 1));
        wr_div(1, 2);
        wr_gate(cb(1, 1));
        repeat (2) @(negedge clk);
        count_pulses(1, 30, cnt);
        chk("R5", "gate low pulses", cnt, 0);
        // R5: gate code 5 also holds
        wr_gate(cb(1, 5));
        repeat (2) @(negedge clk);
        count_pulses(1, 30, cnt);
        chk("R5", "gate code 5 pulses", cnt, 0);
        // R5: external gate
        wr_clk(cb(2, 1));
        wr_div(2, 4);
        ext_gate = 1'b0;
        wr_gate(cb(2, 2));
        repeat (2) @(negedge clk);
        count_pulses(2, 30, cnt);
        chk("R5", "ext gate low pulses", cnt, 0);
        ext_gate = 1'b1;
        meas(2, 100, p);
        chk("R5", "ext gate high period", p, 4);
        // R5: gate code 3 on counter 0 blocked by counter 1 pulses
        wr_gate(cb(1, 0));
        wr_div(1, 2);
        wr_clk(cb(0, 1));
        wr_gate(cb(0, 3));
        wr_div(0, 4);
        meas(0, 200, p);
        chk("R5", "inverted neighbour gate period", p, 8);

        finish_run();
    end
endmodule